// File: doc/BRIEF.md
# Pulse Transition Code Decoder

This block turns a serial stream of 3-bit transition codes back into the data waveform the codes describe. Each code covers one code period. It says whether the data level changes in that period, in which half of the period the change falls, and which level the data takes afterwards. The output is a data level that can move at half-period resolution.

Code bits arrive one at a time on a serial input and are marked by a valid strobe. A bit counter groups every three valid bits into a code, and a 3-bit shift register presents the group in parallel. A complete group is held and takes effect in the code period after the one in which its last bit arrived. Timing comes from a local divider in the single clock domain. The divider makes a half-period tick and a phase level that is high in the first half of each period and low in the second half. The update strobe for the output register is the logical AND of three terms: the half-period tick, the transition flag, and the XNOR of the timing bit with the phase level. The phase level is also driven out so that downstream logic can align to the code periods.

Top module: `ptc_decoder`

## Requirements
- R1: While reset is asserted, and until the first code takes effect, the data output is 0 and the phase output is 0. Reset also clears the bit counter and the shift register.
- R2: Every three valid-strobed bits form one code. The first bit received is the transition flag, the second is the timing bit and the third is the direction bit, and no bit is lost or reused between groups.
- R3: A code whose transition flag is 0 leaves the data level unchanged through the whole period, whatever its timing and direction bits are.
- R4: A flagged code with timing bit 1 sets the new level within two clocks of the start of the first half of its period, and the level is held through both halves.
- R5: A flagged code with timing bit 0 keeps the old level through the first half of its period and sets the new level within two clocks of the start of the second half.
- R6: After a flagged code the level equals the direction bit (1 gives high, 0 gives low). A flagged code whose direction equals the present level leaves the level unchanged.
- R7: A code decodes in the code period that follows the period in which its third bit arrived. A period that follows one with no complete group holds the level.
- R8: The phase output is high for HALF_LEN clocks and then low for HALF_LEN clocks, so a code period is 2*HALF_LEN clocks. Updates happen only in the clock right after a phase change.
- R9: For an arbitrary waveform with at most one transition per period, the output reproduces the waveform level in each half-period, one code period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_bit_i | input | 1 | Serial code bit |
| code_vld_i | input | 1 | Marks code_bit_i as a valid bit in this clock |
| dout_o | output | 1 | Reconstructed data level |
| phase_o | output | 1 | High in the first half of each code period, low in the second |

## Verification
Rising and falling codes are applied in both half-slots, so an error in the XNOR slot selection or in the polarity path shows up as a level that is wrong in one specific half. Unflagged codes carry direction bits that oppose the current level, and flagged codes carry a direction equal to the present level; together they separate a decoder that obeys the flag from one that copies the direction bit regardless. Periods with no group and groups with asymmetric bit patterns test the one-period hand-off and the order in which the bits are assigned. A random waveform, coded by a behavioural encoder, is then compared half by half with itself delayed by one period.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam int CODE_BITS = 3;
  localparam int BCW       = $clog2(CODE_BITS);

  // bit 2: first received (flag), bit 1: timing (1 = early half), bit 0: direction
  typedef struct packed {
    logic flag;
    logic early;
    logic rise;
  } ptc_code_t;

  function automatic ptc_code_t to_code(input logic [CODE_BITS-1:0] raw);
    return ptc_code_t'(raw);
  endfunction

  // the half-slot matches when the timing bit agrees with the phase level
  function automatic logic slot_hit(input logic early, input logic first_half);
    return ~(early ^ first_half);
  endfunction

  function automatic logic group_last(input logic [BCW-1:0] cnt);
    return cnt == BCW'(CODE_BITS - 1);
  endfunction

endpackage

// File: rtl/ptc_timebase.sv
module ptc_timebase #(
  parameter int HALF_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_stb,
  output logic period_start,
  output logic first_half,
  output logic slot_pulse
);
  localparam int CW = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_LEN - 1);

  logic [CW-1:0] cnt;

  assign half_stb     = (cnt == LAST);
  assign period_start = half_stb & ~first_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      first_half <= 1'b0;
      slot_pulse <= 1'b0;
    end else begin
      slot_pulse <= half_stb;
      if (half_stb) begin
        cnt        <= '0;
        first_half <= ~first_half;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptc_deframer.sv
module ptc_deframer
  import ptc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           code_bit,
  input  logic           code_vld,
  input  logic           period_start,
  output ptc_code_t      active,
  output logic [BCW-1:0] bit_cnt,
  output logic           grp_done
);
  logic [CODE_BITS-1:0] shreg;
  ptc_code_t            pend;
  logic                 pend_v;

  assign grp_done = code_vld & group_last(bit_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      active  <= '0;
    end else begin
      if (code_vld) begin
        shreg   <= {shreg[CODE_BITS-2:0], code_bit};
        bit_cnt <= grp_done ? '0 : bit_cnt + 1'b1;
      end
      if (grp_done)
        pend <= to_code({shreg[CODE_BITS-2:0], code_bit});
      if (period_start) begin
        active <= pend_v ? pend : '0;
        pend_v <= grp_done;
      end else if (grp_done) begin
        pend_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptc_slot_gen.sv
module ptc_slot_gen
  import ptc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slot_pulse,
  input  logic      first_half,
  input  ptc_code_t active,
  output logic      upd,
  output logic      dout
);
  assign upd = slot_pulse & active.flag & slot_hit(active.early, first_half);

  always_ff @(posedge clk) begin
    if (!rst_n)   dout <= 1'b0;
    else if (upd) dout <= active.rise;
  end
endmodule

// File: rtl/ptc_decoder.sv
module ptc_decoder
  import ptc_pkg::*;
#(
  parameter int HALF_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic code_bit_i,
  input  logic code_vld_i,
  output logic dout_o,
  output logic phase_o
);
  logic           half_stb;
  logic           period_start;
  logic           first_half;
  logic           slot_pulse;
  logic           upd;
  logic           grp_done;
  logic [BCW-1:0] bit_cnt;
  ptc_code_t      active;

  ptc_timebase #(.HALF_LEN(HALF_LEN)) u_tb (
    .clk          (clk),
    .rst_n        (rst_n),
    .half_stb     (half_stb),
    .period_start (period_start),
    .first_half   (first_half),
    .slot_pulse   (slot_pulse)
  );

  ptc_deframer u_df (
    .clk          (clk),
    .rst_n        (rst_n),
    .code_bit     (code_bit_i),
    .code_vld     (code_vld_i),
    .period_start (period_start),
    .active       (active),
    .bit_cnt      (bit_cnt),
    .grp_done     (grp_done)
  );

  ptc_slot_gen u_sg (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_pulse (slot_pulse),
    .first_half (first_half),
    .active     (active),
    .upd        (upd),
    .dout       (dout_o)
  );

  assign phase_o = first_half;
endmodule

// File: rtl/ptc_decoder_chk.sv
module ptc_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dout_o,
  input logic       phase_o,
  input logic       upd,
  input logic       act_flag,
  input logic       act_rise,
  input logic [1:0] bit_cnt
);
  AST_DOUT_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> $past(upd)); // R3
  AST_UPD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> act_flag); // R3
  AST_DOUT_TAKES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd) |-> dout_o == $past(act_rise)); // R6
  AST_UPD_AFTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !$stable(phase_o)); // R8
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt != 2'd3); // R2
endmodule

bind ptc_decoder ptc_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dout_o   (dout_o),
  .phase_o  (phase_o),
  .upd      (upd),
  .act_flag (active.flag),
  .act_rise (active.rise),
  .bit_cnt  (bit_cnt)
);

// File: tb/tb_ptc_decoder.sv
module tb_ptc_decoder;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_bit = 1'b0;
  logic code_vld = 1'b0;
  logic dout;
  logic phase;

  int    n_cmp = 0;
  int    n_bad = 0;
  logic  lvl = 1'b0;
  logic [2:0] act = 3'b000;
  string act_req = "R7";
  bit    wf_on = 1'b0;
  logic  wf0 = 1'b0;
  logic  wf1 = 1'b0;
  bit    done = 1'b0;

  ptc_decoder #(.HALF_LEN(HALF)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_bit_i (code_bit),
    .code_vld_i (code_vld),
    .dout_o     (dout),
    .phase_o    (phase)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  // one code period: send c (if send) and check the code decoded in this period
  task automatic run_period(input bit send, input logic [2:0] c, input string req);
    logic e1, e2;
    e1 = (act[2] && act[1]) ? act[0] : lvl;
    e2 = act[2] ? act[0] : lvl;
    if (wf_on) begin
      e1 = wf0;
      e2 = wf1;
    end
    for (int k = 0; k < 2*HALF; k++) begin
      if (send && k < 3) begin
        code_vld = 1'b1;
        code_bit = c[2-k];
      end else begin
        code_vld = 1'b0;
        code_bit = 1'b0;
      end
      if (k == 0)        chk("R8", phase, 1'b1, "phase at period start");
      if (k == HALF)     chk("R8", phase, 1'b0, "phase at second half");
      if (k == HALF-1)   chk(act_req, dout, e1, "first half level");
      if (k == 2*HALF-1) chk(act_req, dout, e2, "second half level");
      @(negedge clk);
    end
    lvl     = e2;
    act     = send ? c : 3'b000;
    act_req = send ? req : "R7";
  endtask

  task automatic t_early();
    run_period(1, 3'b111, "R4");
    run_period(1, 3'b110, "R4");
    run_period(1, 3'b111, "R4");
  endtask

  task automatic t_late();
    run_period(1, 3'b100, "R5");
    run_period(1, 3'b101, "R5");
    run_period(1, 3'b100, "R5");
  endtask

  task automatic t_noflag();
    run_period(1, 3'b011, "R3");
    run_period(1, 3'b001, "R3");
    run_period(1, 3'b111, "R6");
    run_period(1, 3'b010, "R3");
    run_period(1, 3'b000, "R3");
  endtask

  task automatic t_same_level();
    run_period(1, 3'b101, "R6");
    run_period(1, 3'b111, "R6");
    run_period(1, 3'b110, "R6");
    run_period(1, 3'b100, "R6");
  endtask

  task automatic t_idle();
    run_period(1, 3'b111, "R7");
    run_period(0, 3'b000, "R7");
    run_period(0, 3'b000, "R7");
    run_period(1, 3'b100, "R7");
  endtask

  task automatic t_frame();
    run_period(1, 3'b101, "R2");
    run_period(1, 3'b110, "R2");
    run_period(1, 3'b011, "R2");
    run_period(1, 3'b101, "R2");
  endtask

  // behavioural encoder on a random waveform with at most one change per period
  task automatic t_random(input int periods);
    logic enc_lvl, h0, h1;
    logic [2:0] c;
    logic ph0, ph1;
    bit have;
    enc_lvl = lvl;
    if (act[2]) enc_lvl = act[0];
    have = 1'b0;
    ph0 = 1'b0;
    ph1 = 1'b0;
    for (int p = 0; p < periods; p++) begin
      h0 = 1'($urandom_range(0, 1));
      h1 = 1'($urandom_range(0, 1));
      if (h0 != enc_lvl) h1 = h0;
      if (h0 != enc_lvl)      c = {1'b1, 1'b1, h0};
      else if (h1 != enc_lvl) c = {1'b1, 1'b0, h1};
      else                    c = {1'b0, 2'($urandom_range(0, 3))};
      wf_on = have;
      wf0   = ph0;
      wf1   = ph1;
      run_period(1, c, "R9");
      enc_lvl = h1;
      ph0 = h0;
      ph1 = h1;
      have = 1'b1;
    end
    wf_on = 1'b1;
    wf0   = ph0;
    wf1   = ph1;
    run_period(0, 3'b000, "R9");
    wf_on = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", dout, 1'b0, "data level in reset");
    chk("R1", phase, 1'b0, "phase in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", dout, 1'b0, "data level after reset");
    while (phase !== 1'b1) @(negedge clk);
    chk("R1", dout, 1'b0, "data level at first period");
    t_early();
    t_late();
    t_noflag();
    t_same_level();
    t_idle();
    t_frame();
    t_random(48);
    run_period(0, 3'b000, "R7");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule